// File: doc/BRIEF.md
# MDIO Management Master

This block is the host side of the two-wire management link to an Ethernet PHY. On a command it produces the management clock by dividing the system clock, and it shifts one complete management frame out on the data line. For a register write the host drives every bit of the frame. For a register read the host lets go of the line for the turnaround and the data field, and it collects the 16 bits that the PHY returns.

The command interface is a one-cycle `start` strobe with the operation, the PHY address, the register address and the write data. While the frame is in progress `busy` stays high. A one-cycle `done` marks the end of the frame, and `rd_data` then holds the value returned by the last completed read. The bidirectional data line appears as three separate signals: output value, output enable and input. The pad is expected to combine them.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, `mdc`, `mdio_oe`, `busy` and `done` are low. `rd_data` resets to zero.
- R2: During a frame, `mdc` is a square wave with a period of 2*HALF_DIV system cycles. It starts low for HALF_DIV cycles and is then high for HALF_DIV cycles. A frame has exactly 64 rising edges.
- R3: Bit times 0 to 31 each carry a 1 with `mdio_oe` high.
- R4: Bit times 32 to 45 carry, most significant bit first, the following fields: a start pattern 0,1; the opcode (read 1,0; write 0,1); the 5-bit PHY address; the 5-bit register address. `mdio_oe` is high throughout.
- R5: In a write, bit times 46 and 47 carry 1,0 and bit times 48 to 63 carry the write data MSB first. `mdio_oe` is high for all 64 bit times.
- R6: In a read, `mdio_oe` is low for bit times 46 to 63.
- R7: In a read, `mdio_in` is sampled at the rising edges of bit times 48 to 63, MSB first. The result appears on `rd_data` in the cycle `done` is high and stays there until the next read completes. A write leaves `rd_data` unchanged.
- R8: `mdio_out` and `mdio_oe` change only together with a falling edge of `mdc`, or at frame start or end. They never change at a rising edge.
- R9: A `start` that arrives while `busy` is high is ignored. The running frame is not altered, and no second frame follows.
- R10: `busy` is high for exactly 128*HALF_DIV cycles per frame. It falls in the same cycle `done` rises, and `done` is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, accepted only when idle |
| cmd_rd | input | 1 | 1 selects a read, 0 a write |
| phy_addr | input | 5 | PHY address for the frame |
| reg_addr | input | 5 | Register address for the frame |
| wr_data | input | 16 | Data for a write |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse at frame end |
| rd_data | output | 16 | Data from the last completed read |
| mdc | output | 1 | Management clock to the PHY |
| mdio_out | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_in | input | 1 | Value sensed on the data line |

## Verification
The frames mix reads and writes. Addresses are all-zero, all-one and alternating patterns, which separate a swapped or misaligned address field from a correct one. The returned and written data words include 0x0000, 0xFFFF, 0xA5A5 and 0x8001: a lost shift, a reversed bit order or a stuck bit each gives a different result on at least one of them. A write placed between reads shows whether `rd_data` holds its value. A start strobe injected in the middle of a frame with different command fields shows whether the running frame, or a queued second frame, can be disturbed.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam logic [1:0] SOF_PAT  = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] TA_HOST  = 2'b10;
    localparam logic [1:0] TA_FLOAT = 2'b11;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic end_stb
);
    localparam int CW = $clog2(2 * HALF_DIV) < 1 ? 1 : $clog2(2 * HALF_DIV);
    localparam logic [CW-1:0] LAST = CW'(2 * HALF_DIV - 1);
    localparam logic [CW-1:0] HIGH_AT = CW'(HALF_DIV);
    localparam logic [CW-1:0] PRE_RISE = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } cg_t;

    cg_t cg_d, cg_q;

    always_comb begin
        cg_d = cg_q;
        if (!run) begin
            cg_d.cnt = '0;
        end else if (cg_q.cnt == LAST) begin
            cg_d.cnt = '0;
        end else begin
            cg_d.cnt = cg_q.cnt + 1'b1;
        end
        cg_d.mdc = run && (cg_d.cnt >= HIGH_AT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cg_q <= '0;
        end else begin
            cg_q <= cg_d;
        end
    end

    assign mdc      = cg_q.mdc;
    assign rise_stb = run && (cg_q.cnt == PRE_RISE);
    assign end_stb  = run && (cg_q.cnt == LAST);

    // R2: the clock drops back low one cycle after the run request goes away
    assert_mdc_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
endmodule

// File: rtl/mdio_bitseq.sv
module mdio_bitseq
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int PA_W    = 5,
    parameter int RA_W    = 5,
    parameter int D_W     = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cmd_rd,
    input  logic [PA_W-1:0] phy_addr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [D_W-1:0]  wr_data,
    input  logic            end_stb,
    output logic            busy,
    output logic            done,
    output logic            mdio_out,
    output logic            mdio_oe,
    output logic            data_win,
    output logic            fin_rd
);
    localparam int FRAME_LEN = PRE_LEN + 6 + PA_W + RA_W + D_W;
    localparam int BW        = $clog2(FRAME_LEN + 1);
    localparam int TA_IDX    = PRE_LEN + 4 + PA_W + RA_W;
    localparam int DAT_IDX   = TA_IDX + 2;
    localparam logic [BW-1:0] LAST_IDX = BW'(FRAME_LEN - 1);

    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic                 rd;
        logic [BW-1:0]        idx;
        logic [FRAME_LEN-1:0] sh;
    } seq_t;

    seq_t sq_d, sq_q;
    logic last_bit;

    assign last_bit = sq_q.busy && end_stb && (sq_q.idx == LAST_IDX);

    always_comb begin
        sq_d      = sq_q;
        sq_d.done = 1'b0;
        if (!sq_q.busy) begin
            if (start) begin
                sq_d.busy = 1'b1;
                sq_d.rd   = cmd_rd;
                sq_d.idx  = '0;
                sq_d.sh   = {{PRE_LEN{1'b1}}, SOF_PAT,
                             cmd_rd ? OP_READ : OP_WRITE,
                             phy_addr, reg_addr,
                             cmd_rd ? TA_FLOAT : TA_HOST,
                             cmd_rd ? {D_W{1'b0}} : wr_data};
            end
        end else if (end_stb) begin
            if (last_bit) begin
                sq_d.busy = 1'b0;
                sq_d.done = 1'b1;
                sq_d.idx  = '0;
            end else begin
                sq_d.idx = sq_q.idx + 1'b1;
                sq_d.sh  = {sq_q.sh[FRAME_LEN-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sq_q <= '0;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy     = sq_q.busy;
    assign done     = sq_q.done;
    assign mdio_out = sq_q.busy && sq_q.sh[FRAME_LEN-1];
    assign mdio_oe  = sq_q.busy && (!sq_q.rd || (sq_q.idx < BW'(TA_IDX)));
    assign data_win = sq_q.busy && sq_q.rd && (sq_q.idx >= BW'(DAT_IDX));
    assign fin_rd   = last_bit && sq_q.rd;

    assert_idx_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.busy |-> (sq_q.idx <= LAST_IDX));
    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.done |=> !sq_q.done);
    // R9: a start strobe cannot reload the frame once it is running
    assert_cmd_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.busy && !end_stb) |=> ($stable(sq_q.sh) && $stable(sq_q.rd)));
endmodule

// File: rtl/mdio_rdcap.sv
module mdio_rdcap #(
    parameter int D_W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sample,
    input  logic           mdio_in,
    input  logic           commit,
    output logic [D_W-1:0] rd_data
);
    typedef struct packed {
        logic [D_W-1:0] sh;
        logic [D_W-1:0] hold;
    } cap_t;

    cap_t cp_d, cp_q;

    always_comb begin
        cp_d = cp_q;
        if (sample) begin
            cp_d.sh = {cp_q.sh[D_W-2:0], mdio_in};
        end
        if (commit) begin
            cp_d.hold = cp_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp_q <= '0;
        end else begin
            cp_q <= cp_d;
        end
    end

    assign rd_data = cp_q.hold;

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(rd_data));
endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
    parameter int HALF_DIV = 2,
    parameter int PRE_LEN  = 32,
    parameter int PA_W     = 5,
    parameter int RA_W     = 5,
    parameter int D_W      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            cmd_rd,
    input  logic [PA_W-1:0] phy_addr,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [D_W-1:0]  wr_data,
    output logic            busy,
    output logic            done,
    output logic [D_W-1:0]  rd_data,
    output logic            mdc,
    output logic            mdio_out,
    output logic            mdio_oe,
    input  logic            mdio_in
);
    logic rise_stb, end_stb, data_win, fin_rd;

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy),
        .mdc(mdc), .rise_stb(rise_stb), .end_stb(end_stb)
    );

    mdio_bitseq #(.PRE_LEN(PRE_LEN), .PA_W(PA_W), .RA_W(RA_W), .D_W(D_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_rd(cmd_rd),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .end_stb(end_stb), .busy(busy), .done(done),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe),
        .data_win(data_win), .fin_rd(fin_rd)
    );

    mdio_rdcap #(.D_W(D_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .sample(rise_stb && data_win),
        .mdio_in(mdio_in), .commit(fin_rd), .rd_data(rd_data)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdio_oe && !mdc));
    assert_line_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_out) && $stable(mdio_oe)));
    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> ($fell(busy)));
endmodule

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
    localparam int HALF = 2;
    localparam int NV = 7;
    // {rd, phy, reg, wdata, phy_reply}
    localparam logic [42:0] VEC [NV] = '{
        {1'b0, 5'h01, 5'h00, 16'h1200, 16'h0000},
        {1'b1, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF},
        {1'b1, 5'h00, 5'h02, 16'h0000, 16'h0000},
        {1'b0, 5'h15, 5'h0A, 16'hA5A5, 16'h0000},
        {1'b1, 5'h0A, 5'h15, 16'h0000, 16'h5A3C},
        {1'b0, 5'h1F, 5'h1F, 16'hFFFF, 16'h0000},
        {1'b1, 5'h12, 5'h04, 16'h0000, 16'h8001}
    };

    logic clk = 0, rst_n = 0, start = 0, cmd_rd = 0, mdio_in = 1;
    logic [4:0] phy_addr = '0, reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic busy, done, mdc, mdio_out, mdio_oe;
    logic [15:0] rd_data;

    int n_chk = 0, n_bad = 0;
    int edge_cnt = 0, hi_cnt = 0;
    logic [15:0] reply_q = '0, last_rd = '0;
    logic [63:0] host_cap = '0, oe_cap = '0;

    always #2 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_rd(cmd_rd),
        .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
        .busy(busy), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    function automatic logic phy_bit(int b);
        if (b == 47) return 1'b0;
        if (b >= 48 && b <= 63) return reply_q[63 - b];
        return 1'b1;
    endfunction

    // PHY model: record the line at each rising edge, then present the next bit
    always @(posedge mdc) begin
        #1;
        if (edge_cnt < 64) begin
            host_cap[63 - edge_cnt] = mdio_out;
            oe_cap[63 - edge_cnt]   = mdio_oe;
        end
        edge_cnt = edge_cnt + 1;
        mdio_in = phy_bit(edge_cnt);
    end

    always @(negedge clk) if (mdc) hi_cnt = hi_cnt + 1;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [15:0] rep, input int poke_at);
        int busy_cnt;
        int it;
        logic [63:0] exp_f, exp_oe;
        @(negedge clk);
        cmd_rd = rd; phy_addr = pa; reg_addr = ra; wr_data = wd;
        reply_q = rep; edge_cnt = 0; hi_cnt = 0; mdio_in = 1;
        host_cap = '0; oe_cap = '0;
        start = 1;
        @(negedge clk);
        start = 0;
        busy_cnt = 0;
        it = 0;
        while (it < 4000) begin
            if (busy) busy_cnt++;
            if (done) break;
            if (it == poke_at) begin
                start = 1; cmd_rd = ~rd; phy_addr = ~pa; reg_addr = ~ra; wr_data = ~wd;
            end else begin
                start = 0;
            end
            it++;
            @(negedge clk);
        end
        start = 0;
        exp_f  = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, pa, ra,
                  rd ? 2'b00 : 2'b10, rd ? 16'h0000 : wd};
        exp_oe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
        chk(done, "R10 done seen", {63'b0, done}, 64'd1);
        chk(busy_cnt == 128 * HALF, "R10 busy length", 64'(busy_cnt), 64'(128 * HALF));
        chk(edge_cnt == 64, "R2 rising edges", 64'(edge_cnt), 64'd64);
        chk(hi_cnt == 64 * HALF, "R2 high cycles", 64'(hi_cnt), 64'(64 * HALF));
        chk(oe_cap == exp_oe, rd ? "R6 read drive window" : "R5 write drive window", oe_cap, exp_oe);
        chk((host_cap & exp_oe) == (exp_f & exp_oe), "R3 R4 R5 host bits", host_cap & exp_oe, exp_f & exp_oe);
        if (rd) last_rd = rep;
        chk(rd_data == last_rd, rd ? "R7 read data" : "R7 write keeps rd_data", 64'(rd_data), 64'(last_rd));
        @(negedge clk);
        chk(!done && !busy, "R10 done single", {62'b0, done, busy}, 64'd0);
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog R10 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(!busy && !done && !mdc && !mdio_oe, "R1 reset idle",
            {60'b0, busy, done, mdc, mdio_oe}, 64'd0);
        chk(rd_data == 16'h0, "R1 reset rd_data", 64'(rd_data), 64'd0);

        for (int v = 0; v < NV; v++) begin
            run_frame(VEC[v][42], VEC[v][41:37], VEC[v][36:32], VEC[v][31:16], VEC[v][15:0], -1);
        end

        // R9: strobe with inverted command fields in the middle of a write frame
        run_frame(1'b0, 5'h03, 5'h11, 16'h3C3C, 16'h0000, 40);
        repeat (20) begin
            @(negedge clk);
            chk(!busy && !mdc && !mdio_oe, "R9 no second frame",
                {61'b0, busy, mdc, mdio_oe}, 64'd0);
        end
        // R9 in a read, with a late poke near the end of the data field
        run_frame(1'b1, 5'h0C, 5'h07, 16'h0000, 16'h0001, 240);
        repeat (5) @(negedge clk);
        chk(!busy && !mdc && !mdio_oe && !done, "R1 idle after frames",
            {60'b0, busy, mdc, mdio_oe, done}, 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule